// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block sits between an AXI-side requester and a PCIe-side request builder and rewrites each 32-bit AXI address into a 64-bit PCIe address. Software programs up to `NWIN` windows through a simple register port. Each window has an enable bit, a type (configuration, I/O or memory), a size held as a 64-bit mask, an AXI base address and a 64-bit target address. The low half of the size mask shares a word with the enable and type bits. The high half sits in a separate extension word.

For each lookup the unit compares the address against every window in parallel. The lowest-numbered enabled window whose base matches under its size mask wins. The unit then reports a hit with the translated address and the window's type. If nothing matches, it reports a miss with a zero address. The result is registered and appears one cycle after the request. For configuration windows, software places the bus, device and function numbers in the target address. The low 12 address bits then carry the register offset untouched into the translated address.

The result stage is a three-state machine. `RS_IDLE` means no result this cycle, `RS_HIT` means a translated address is presented, and `RS_MISS` means no window matched. On every clock the machine moves from any state as follows:
- to `RS_HIT` when a request arrives and some window matches;
- to `RS_MISS` when a request arrives and no window matches;
- to `RS_IDLE` when no request arrives.

Reset places it in `RS_IDLE`.

Top module: `ob_xlate`

## Requirements
- R1: After reset every window is disabled, every window register reads 0, and every lookup reports a miss.
- R2: Window w's registers are placed at these word addresses: control at 0x0BA0+16w, AXI base at 0x0BA4+16w, target low at 0x0BA8+16w, target high at 0x0BAC+16w, and upper size mask at 0xBAF0+4w. The control word holds enable in bit 0, type in bits [2:1] and mask bits in [31:12], and reads back with bits [11:3] as 0.
- R3: A write to an AXI base register stores the value with bits [1:0] cleared.
- R4: A window hits when it is enabled and (address AND mask_low) equals (base AND mask_low). Mask_low is control bits [31:12] with bits [11:0] zero.
- R5: On a hit, out_addr = (target AND mask) OR (zero-extended address AND NOT mask). Here mask = {upper size word, mask_low}.
- R6: When several windows hit, the lowest-numbered one is used.
- R7: On a miss, out_miss=1, out_hit=0, out_addr=0 and out_type=0. Exactly one of out_hit and out_miss is 1 whenever out_valid is 1.
- R8: A disabled window never hits, even when the address matches its base.
- R9: out_valid is 1 exactly in the cycle after in_valid was sampled 1. While out_valid is 0, out_hit, out_miss, out_addr and out_type are 0. Back-to-back requests give back-to-back results.
- R10: On a hit, out_type equals the type field of the winning window (0 configuration, 1 I/O, 2 memory).
- R11: A 4 KB configuration window whose target low word is bus<<24 | device<<19 | function<<16 translates to that word with the address's low 12 bits in [11:0].
- R12: Control bits [11:0] and base bits [11:0] take no part in matching. An address that differs from the base only below bit 12 hits a 4 KB window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| in_valid | input | 1 | Lookup request valid |
| in_addr | input | 32 | AXI address to translate |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_hit | output | 1 | A window matched |
| out_miss | output | 1 | No window matched |
| out_addr | output | 64 | Translated PCIe address |
| out_type | output | 2 | Type of the winning window |

## Verification
The bench aims at overlapping windows. A priority encoder that favoured the highest index would send an address inside window 0 to a catch-all window 1. It also checks a window whose size reaches beyond 32 bits. A design that ignored the extension word would pass upper address bits from the wrong source. Disabling a window that still matches must drop its hits, and a design that looked only at the mask would keep translating. Base and control bits below the 4 KB granule are deliberately set to junk. A design that compared them would miss configuration accesses that should hit. A design that let a miss carry stale data would show a non-zero address or type.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;

    // Window type encoding, held in control bits [2:1]
    typedef enum logic [1:0] {
        WT_CFG  = 2'd0,
        WT_IO   = 2'd1,
        WT_MEM  = 2'd2,
        WT_RSVD = 2'd3
    } win_type_e;

    // Result stage states
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_HIT  = 2'd1,
        RS_MISS = 2'd2
    } res_state_e;

    // One programmed window
    typedef struct packed {
        logic        en;
        win_type_e   wtype;
        logic [31:0] mask_lo;
        logic [31:0] mask_hi;
        logic [31:0] base;
        logic [63:0] target;
    } win_cfg_t;

    // Register placement (software decodes these offsets)
    localparam int CTRL_OFS     = 'h0BA0;
    localparam int WIN_STRIDE   = 16;
    localparam int EXT_OFS      = 'hBAF0;
    localparam int EXT_STRIDE   = 4;
    localparam int GRANULE_BITS = 12;

endpackage

// File: rtl/ob_xlate_regs.sv
module ob_xlate_regs
    import ob_xlate_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int RAW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output win_cfg_t        cfg_o [NWIN]
);
    localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam logic [RAW-1:0] MAIN_BASE = RAW'(CTRL_OFS);
    localparam logic [RAW-1:0] MAIN_SPAN = RAW'(WIN_STRIDE * NWIN);
    localparam logic [RAW-1:0] EXT_BASE  = RAW'(EXT_OFS);
    localparam logic [RAW-1:0] EXT_SPAN  = RAW'(EXT_STRIDE * NWIN);

    win_cfg_t       cfg_q [NWIN];
    logic [RAW-1:0] main_off, ext_off;
    logic           main_sel, ext_sel;
    logic [IW-1:0]  main_win, ext_win;
    logic [1:0]     fld;
    logic [NWIN-1:0] en_vec;

    always_comb begin
        main_off = reg_addr - MAIN_BASE;
        ext_off  = reg_addr - EXT_BASE;
        main_sel = (reg_addr >= MAIN_BASE) && (main_off < MAIN_SPAN) && (reg_addr[1:0] == 2'b00);
        ext_sel  = (reg_addr >= EXT_BASE) && (ext_off < EXT_SPAN) && (reg_addr[1:0] == 2'b00);
        main_win = main_off[IW+3:4];
        ext_win  = ext_off[IW+1:2];
        fld      = main_off[3:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NWIN; w++) cfg_q[w] <= '0;
        end else if (reg_we) begin
            if (main_sel) begin
                unique case (fld)
                    2'd0: begin
                        cfg_q[main_win].en      <= reg_wdata[0];
                        cfg_q[main_win].wtype   <= win_type_e'(reg_wdata[2:1]);
                        cfg_q[main_win].mask_lo <= {reg_wdata[31:GRANULE_BITS], {GRANULE_BITS{1'b0}}};
                    end
                    2'd1: cfg_q[main_win].base          <= {reg_wdata[31:2], 2'b00};
                    2'd2: cfg_q[main_win].target[31:0]  <= reg_wdata;
                    2'd3: cfg_q[main_win].target[63:32] <= reg_wdata;
                endcase
            end
            if (ext_sel) cfg_q[ext_win].mask_hi <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (main_sel) begin
            unique case (fld)
                2'd0: reg_rdata = {cfg_q[main_win].mask_lo[31:GRANULE_BITS],
                                   {(GRANULE_BITS-3){1'b0}},
                                   cfg_q[main_win].wtype, cfg_q[main_win].en};
                2'd1: reg_rdata = cfg_q[main_win].base;
                2'd2: reg_rdata = cfg_q[main_win].target[31:0];
                2'd3: reg_rdata = cfg_q[main_win].target[63:32];
            endcase
        end else if (ext_sel) begin
            reg_rdata = cfg_q[ext_win].mask_hi;
        end
    end

    always_comb begin
        for (int w = 0; w < NWIN; w++) en_vec[w] = cfg_q[w].en;
    end

    assign cfg_o = cfg_q;

    // R1: leaving reset, no window is enabled
    assert_reset_disabled_R1: assert property (@(posedge clk) $rose(rst_n) |-> (en_vec == '0));

endmodule

// File: rtl/ob_xlate_win.sv
module ob_xlate_win
    import ob_xlate_pkg::*;
(
    input  win_cfg_t    cfg_i,
    input  logic [31:0] addr_i,
    output logic        hit_o,
    output logic [63:0] xaddr_o,
    output win_type_e   type_o
);
    logic [63:0] mask64;

    always_comb begin
        mask64  = {cfg_i.mask_hi, cfg_i.mask_lo};
        hit_o   = cfg_i.en && (((addr_i ^ cfg_i.base) & cfg_i.mask_lo) == 32'h0);
        xaddr_o = (cfg_i.target & mask64) | ({32'h0, addr_i} & ~mask64);
        type_o  = cfg_i.wtype;
    end

endmodule

// File: rtl/ob_xlate_prio.sv
module ob_xlate_prio
    import ob_xlate_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NWIN-1:0] hits_i,
    input  logic [63:0]     xaddr_i [NWIN],
    input  win_type_e       types_i [NWIN],
    output logic            any_o,
    output logic [63:0]     addr_o,
    output win_type_e       type_o
);
    logic [NWIN-1:0] lower;
    logic [NWIN-1:0] grant;

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_chain
            if (w == 0) begin : g_first
                assign lower[w] = 1'b0;
            end else begin : g_rest
                assign lower[w] = lower[w-1] | hits_i[w-1];
            end
            assign grant[w] = hits_i[w] & ~lower[w];
        end
    endgenerate

    always_comb begin
        any_o  = |hits_i;
        addr_o = '0;
        type_o = WT_CFG;
        for (int w = 0; w < NWIN; w++) begin
            if (grant[w]) begin
                addr_o = xaddr_i[w];
                type_o = types_i[w];
            end
        end
    end

    // R6: at most one window is granted
    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
    // R4: some window is granted exactly when some window hits
    assert_grant_covers_R4: assert property (@(posedge clk) disable iff (!rst_n) (|hits_i) == (|grant));

endmodule

// File: rtl/ob_xlate.sv
module ob_xlate
    import ob_xlate_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int RAW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            in_valid,
    input  logic [31:0]     in_addr,
    output logic            out_valid,
    output logic            out_hit,
    output logic            out_miss,
    output logic [63:0]     out_addr,
    output logic [1:0]      out_type
);
    win_cfg_t        cfg [NWIN];
    logic [NWIN-1:0] hits;
    logic [63:0]     xaddr [NWIN];
    win_type_e       wtypes [NWIN];
    logic            any_hit;
    logic [63:0]     sel_addr;
    win_type_e       sel_type;

    res_state_e      rs_q, rs_d;
    logic [63:0]     addr_q;
    win_type_e       type_q;

    ob_xlate_regs #(.NWIN(NWIN), .RAW(RAW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_o     (cfg)
    );

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            ob_xlate_win u_win (
                .cfg_i   (cfg[w]),
                .addr_i  (in_addr),
                .hit_o   (hits[w]),
                .xaddr_o (xaddr[w]),
                .type_o  (wtypes[w])
            );
        end
    endgenerate

    ob_xlate_prio #(.NWIN(NWIN)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .hits_i  (hits),
        .xaddr_i (xaddr),
        .types_i (wtypes),
        .any_o   (any_hit),
        .addr_o  (sel_addr),
        .type_o  (sel_type)
    );

    // Next-state: every state leaves on the same three conditions
    always_comb begin
        unique case ({in_valid, any_hit})
            2'b11:   rs_d = RS_HIT;
            2'b10:   rs_d = RS_MISS;
            default: rs_d = RS_IDLE;
        endcase
    end

    // State register and captured result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q   <= RS_IDLE;
            addr_q <= '0;
            type_q <= WT_CFG;
        end else begin
            rs_q   <= rs_d;
            addr_q <= sel_addr;
            type_q <= sel_type;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        out_valid = 1'b0;
        out_hit   = 1'b0;
        out_miss  = 1'b0;
        out_addr  = '0;
        out_type  = WT_CFG;
        unique case (rs_q)
            RS_HIT: begin
                out_valid = 1'b1;
                out_hit   = 1'b1;
                out_addr  = addr_q;
                out_type  = type_q;
            end
            RS_MISS: begin
                out_valid = 1'b1;
                out_miss  = 1'b1;
            end
            default: ;
        endcase
    end

    // R7: exactly one flag with every result
    assert_one_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hit ^ out_miss));
    // R7: a miss carries no address or type
    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> (out_addr == 64'h0 && out_type == 2'd0));
    // R9: result follows a request by one cycle
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R9: no request, no result
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_hit && !out_miss && out_addr == 64'h0));

endmodule

// File: tb/ob_xlate_bench.sv
module ob_xlate_bench;
    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid, out_hit, out_miss;
    logic [63:0] out_addr;
    logic [1:0]  out_type;

    always #5 clk = ~clk;

    ob_xlate #(.NWIN(NW), .RAW(16)) u_ob_xlate (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit),
        .out_miss(out_miss), .out_addr(out_addr), .out_type(out_type)
    );

    // Behavioural model state
    logic        m_en   [NW];
    logic [1:0]  m_ty   [NW];
    logic [31:0] m_mlo  [NW];
    logic [31:0] m_mhi  [NW];
    logic [31:0] m_base [NW];
    logic [31:0] m_tlo  [NW];
    logic [31:0] m_thi  [NW];

    logic        e_valid, e_hit, e_miss;
    logic [63:0] e_addr;
    logic [1:0]  e_type;
    string       e_tag = "R1";
    string       tag = "R1";
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          cmp_on = 0;
    bit          done = 0;

    // Reference model: result from state before this edge's write
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                m_en[w] = 0; m_ty[w] = 0; m_mlo[w] = 0; m_mhi[w] = 0;
                m_base[w] = 0; m_tlo[w] = 0; m_thi[w] = 0;
            end
            e_valid = 0; e_hit = 0; e_miss = 0; e_addr = 0; e_type = 0; e_tag = "R1";
        end else begin
            int win;
            logic [63:0] mk;
            win = -1;
            for (int w = NW - 1; w >= 0; w--)
                if (m_en[w] && (((in_addr ^ m_base[w]) & m_mlo[w]) == 0)) win = w;
            e_valid = in_valid;
            e_hit   = in_valid && (win >= 0);
            e_miss  = in_valid && (win < 0);
            e_addr  = 0;
            e_type  = 0;
            e_tag   = in_valid ? tag : "R9";
            if (e_hit) begin
                mk     = {m_mhi[win], m_mlo[win]};
                e_addr = ({m_thi[win], m_tlo[win]} & mk) | ({32'h0, in_addr} & ~mk);
                e_type = m_ty[win];
            end
            if (reg_we) begin
                int a;
                a = int'(reg_addr);
                if (a >= 'h0BA0 && a < 'h0BA0 + 16 * NW && a % 4 == 0) begin
                    int w, f;
                    w = (a - 'h0BA0) / 16;
                    f = ((a - 'h0BA0) % 16) / 4;
                    case (f)
                        0: begin m_en[w] = reg_wdata[0]; m_ty[w] = reg_wdata[2:1];
                                 m_mlo[w] = reg_wdata & 32'hFFFF_F000; end
                        1: m_base[w] = reg_wdata & 32'hFFFF_FFFC;
                        2: m_tlo[w] = reg_wdata;
                        default: m_thi[w] = reg_wdata;
                    endcase
                end
                if (a >= 'hBAF0 && a < 'hBAF0 + 4 * NW && a % 4 == 0)
                    m_mhi[(a - 'hBAF0) / 4] = reg_wdata;
            end
        end
    end

    // Compare on every clock
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            n_cmp++;
            if (out_valid !== e_valid || out_hit !== e_hit || out_miss !== e_miss ||
                out_addr !== e_addr || out_type !== e_type) begin
                n_bad++;
                $display("FAIL %s: got v=%0b h=%0b m=%0b a=%h t=%0d exp v=%0b h=%0b m=%0b a=%h t=%0d",
                         e_tag, out_valid, out_hit, out_miss, out_addr, out_type,
                         e_valid, e_hit, e_miss, e_addr, e_type);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string t);
        @(negedge clk);
        reg_we = 0; reg_addr = a;
        #1;
        n_cmp++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: reg %h read %h expected %h", t, a, reg_rdata, exp);
        end
    endtask

    task automatic look(input logic [31:0] a, input string t);
        @(negedge clk);
        tag = t; in_valid = 1; in_addr = a;
        @(negedge clk);
        in_valid = 0;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        logic [31:0] rs;
        rs = 32'h1357_9BDF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;

        // R1: reset state
        rd_chk(16'h0BA0, 32'h0, "R1");
        rd_chk(16'hBAF0, 32'h0, "R1");
        look(32'h4000_1234, "R1");
        look(32'h0000_0000, "R1");

        // R2: window 0 memory, 64 KB, junk in control bits 11:3
        wr(16'h0BA0, 32'hFFFF_0FF5);
        wr(16'hBAF0, 32'hFFFF_FFFF);
        wr(16'h0BA4, 32'h4000_0000);
        wr(16'h0BA8, 32'h2345_0000);
        wr(16'h0BAC, 32'h0000_0001);
        rd_chk(16'h0BA0, 32'hFFFF_0005, "R2");
        rd_chk(16'h0BA8, 32'h2345_0000, "R2");
        rd_chk(16'h0BAC, 32'h0000_0001, "R2");
        rd_chk(16'hBAF0, 32'hFFFF_FFFF, "R2");
        look(32'h4000_1234, "R5");
        look(32'h4001_0000, "R7");
        look(32'h3FFF_FFFC, "R7");

        // R3: base alignment
        wr(16'h0BB4, 32'h5000_0003);
        rd_chk(16'h0BB4, 32'h5000_0000, "R3");

        // R5/R6/R10: window 1 I/O catch-all, size beyond 32 bits
        wr(16'h0BB0, 32'h0000_0003);
        wr(16'hBAF4, 32'hFFFF_FFF0);
        wr(16'h0BB8, 32'h0000_0000);
        wr(16'h0BBC, 32'h0000_0050);
        look(32'h4000_0010, "R6");
        look(32'h9000_0000, "R10");

        // R8: disable window 0 while it still matches
        wr(16'h0BA0, 32'hFFFF_0004);
        look(32'h4000_0010, "R8");
        wr(16'h0BB0, 32'h0000_0000);
        look(32'h4000_0010, "R8");

        // R11/R12: configuration window, bus 3 device 5 function 2
        wr(16'h0BC0, 32'hFFFF_F001);
        wr(16'hBAF8, 32'hFFFF_FFFF);
        wr(16'h0BC4, 32'h6000_0ABC);
        wr(16'h0BC8, (32'd3 << 24) | (32'd5 << 19) | (32'd2 << 16));
        wr(16'h0BCC, 32'h0);
        look(32'h6000_0010, "R11");
        look(32'h6000_0FFF, "R12");
        look(32'h6000_1000, "R12");

        // R9: back-to-back and gapped requests
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            tag = "R9";
            in_valid = (i % 5) != 3;
            in_addr = 32'h6000_0000 + 32'(i * 'h800);
        end
        @(negedge clk);
        in_valid = 0;

        // R4: randomised windows and near-base addresses
        for (int k = 0; k < 48; k++) begin
            int w, sz;
            logic [31:0] mlo, base;
            w = k % NW;
            rs = nxt(rs);
            sz = 12 + int'(rs[7:4]);
            mlo = ~((32'h1 << sz) - 32'h1);
            wr(16'h0BA0 + 16'(w * 16), mlo | {29'h0, rs[2:1], rs[0] | rs[9]});
            rs = nxt(rs);
            base = rs;
            wr(16'h0BA4 + 16'(w * 16), base);
            rs = nxt(rs);
            wr(16'h0BA8 + 16'(w * 16), rs);
            wr(16'h0BAC + 16'(w * 16), {24'h0, rs[7:0]});
            wr(16'hBAF0 + 16'(w * 4), 32'hFFFF_FFFF);
            for (int j = 0; j < 6; j++) begin
                rs = nxt(rs);
                look(base ^ (rs & ((32'h2 << sz) - 32'h1)), "R4");
            end
        end

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule